// File: doc/BRIEF.md
# Daisy-Chainable Serial DAC Input Register

This block is the serial front end of a 16-bit current-loop DAC. A host drives three lines: a serial clock, a data line and a latch strobe. All three are sampled by the block's own system clock through a synchronizer. Every rising edge seen on the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. The register's top bit is presented on a serial output. Several blocks can therefore be wired in a chain and behave as one long shift register. A rising edge on the latch strobe copies the shift register into a holding register, and the holding register supplies the DAC code.

An asynchronous clear forces the code to zero, which is the bottom of whichever span is selected. The clear also raises a clear flag and blocks updates while it is held. It leaves the shift register untouched. A two-bit range select is decoded into a one-hot span indication for the analog stage. After reset the code is zero, so the output starts at the low end of the selected range.

Control is a three-state machine. IDLE means no bits have arrived since the last update. SHIFT means bits have been received. UPDATE is a window of `UPD_CYCLES` clocks in which the holding register loads and the serial clock is ignored. The transitions are:
- IDLE to SHIFT on a serial clock edge.
- IDLE or SHIFT to UPDATE on a latch edge. The latch edge wins over a serial clock edge detected in the same cycle.
- UPDATE to IDLE when the window ends.

Top module: `dacin_serial_front`

## Requirements
- R1: After reset `code_o` is 0, `upd_o` is 0, `clr_flag_o` is 0 and `sdo_o` is 0.
- R2: Each rising edge seen on `sclk_i` outside the update window shifts `sdi_i` into bit 0 of the shift register, with the earlier bits moving toward bit 15. A word is therefore sent MSB first over 16 clocks.
- R3: `sdo_o` always shows bit 15 of the shift register. In a chain of two blocks, the first 16 bits clocked end in the far block and the last 16 bits stay in the near block.
- R4: A rising edge on `latch_i` copies the shift register into `code_o`. `upd_o` pulses high for exactly one clock in the cycle the new code first appears.
- R5: Rising edges on `sclk_i` that are detected during the `UPD_CYCLES`-clock update window are ignored and leave the shift register unchanged.
- R6: While `clr_i` is high, `code_o` is 0 and `clr_flag_o` is 1. A latch request issued during the clear produces no `upd_o` pulse. After release, `code_o` stays 0 until the next latch and `clr_flag_o` falls within one clock.
- R7: A clear does not alter the shift register. A latch after release with no new bits restores the word shifted before the clear.
- R8: `span_o` is one-hot and bit k is set for `range_sel_i` = k: 0 is 0–5 V, 1 is 4–20 mA, 2 is 0–20 mA, 3 is 0–24 mA. Bit 1 of `range_sel_i` is the high select line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host or previous stage |
| sdi_i | input | 1 | Serial data in |
| latch_i | input | 1 | Latch strobe, acts on its rising edge |
| clr_i | input | 1 | Asynchronous clear, active high |
| range_sel_i | input | 2 | Span select |
| sdo_o | output | 1 | Serial data out, MSB of shift register |
| code_o | output | WIDTH | Latched DAC code |
| upd_o | output | 1 | One-clock pulse when a new code is loaded |
| clr_flag_o | output | 1 | Clear active |
| span_o | output | 4 | One-hot decoded span |

## Verification
The bench builds two instances with the defaults: WIDTH 16, two synchronizer stages and a four-clock update window. The far instance takes its data from the near instance's serial output, so the 32-bit chain ordering is visible at the ports. The short update window lets the bench place a serial clock edge inside it at a known cycle. The two-stage synchronizer keeps the latency from a host edge to the code at a few clocks, so each expected update can be matched by a scoreboard queue per instance.

// File: rtl/dacin_pkg.sv
package dacin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_UPDATE = 2'd2
    } fe_state_t;

    typedef enum logic [1:0] {
        SPAN_V5    = 2'b00,
        SPAN_I4_20 = 2'b01,
        SPAN_I0_20 = 2'b10,
        SPAN_I0_24 = 2'b11
    } span_t;

    localparam int NUM_SPANS = 4;

endpackage

// File: rtl/dacin_sync.sv
module dacin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st[g] <= '0;
                else        st[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st[g] <= '0;
                else        st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/dacin_edge.sv
module dacin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic latch_i,
    output logic sclk_rise,
    output logic latch_rise,
    output logic sdi_s
);

    logic [2:0] raw, syn;
    logic       sclk_prev, latch_prev;

    assign raw = {latch_i, sdi_i, sclk_i};

    dacin_sync #(.STAGES(STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            latch_prev <= 1'b0;
        end else begin
            sclk_prev  <= syn[0];
            latch_prev <= syn[2];
        end
    end

    assign sclk_rise  = syn[0] & ~sclk_prev;
    assign latch_rise = syn[2] & ~latch_prev;
    assign sdi_s      = syn[1];

endmodule

// File: rtl/dacin_shift.sv
module dacin_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_o,
    output logic         msb_o
);

    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[W-2:0], din};
    end

    assign word_o = sr;
    assign msb_o  = sr[W-1];

endmodule

// File: rtl/dacin_hold.sv
module dacin_hold
    import dacin_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 load_en,
    input  logic [W-1:0]         word_i,
    input  logic [1:0]           range_sel_i,
    output logic [W-1:0]         code_o,
    output logic                 upd_o,
    output logic                 clr_flag_o,
    output logic [NUM_SPANS-1:0] span_o
);

    logic [W-1:0]         hold_q;
    logic                 upd_q;
    logic                 clr_q;
    logic [NUM_SPANS-1:0] span_q;
    logic [NUM_SPANS-1:0] span_d;

    always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
        if (!rst_n) begin
            hold_q <= '0;
            upd_q  <= 1'b0;
        end else if (clr_i) begin
            hold_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= load_en;
            if (load_en) hold_q <= word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
        if (!rst_n)     clr_q <= 1'b0;
        else if (clr_i) clr_q <= 1'b1;
        else            clr_q <= 1'b0;
    end

    always_comb begin
        span_d = '0;
        unique case (span_t'(range_sel_i))
            SPAN_V5:    span_d[0] = 1'b1;
            SPAN_I4_20: span_d[1] = 1'b1;
            SPAN_I0_20: span_d[2] = 1'b1;
            SPAN_I0_24: span_d[3] = 1'b1;
            default:    span_d[0] = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) span_q <= 4'b0001;
        else        span_q <= span_d;
    end

    assign code_o     = hold_q;
    assign upd_o      = upd_q;
    assign clr_flag_o = clr_q;
    assign span_o     = span_q;

    // R6: code held at bottom of span while clear is asserted
    a_r6_clear_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> (code_o == '0 && clr_flag_o));

    // R8: exactly one span indicated
    a_r8_span_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(span_o) == 1);

    // R4: update pulse lasts a single cycle
    a_r4_upd_single: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        upd_o |=> !upd_o);

endmodule

// File: rtl/dacin_serial_front.sv
module dacin_serial_front
    import dacin_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int UPD_CYCLES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             latch_i,
    input  logic             clr_i,
    input  logic [1:0]       range_sel_i,
    output logic             sdo_o,
    output logic [WIDTH-1:0] code_o,
    output logic             upd_o,
    output logic             clr_flag_o,
    output logic [3:0]       span_o
);

    localparam int CW = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(UPD_CYCLES - 1);

    fe_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            sclk_rise, latch_rise, sdi_s;
    logic            shift_en, load_en;
    logic [WIDTH-1:0] shift_word;
    logic            shift_msb;

    dacin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .sdi_i      (sdi_i),
        .latch_i    (latch_i),
        .sclk_rise  (sclk_rise),
        .latch_rise (latch_rise),
        .sdi_s      (sdi_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != ST_UPDATE) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (latch_rise)     state_d = ST_UPDATE;
                else if (sclk_rise) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (latch_rise)     state_d = ST_UPDATE;
            end
            ST_UPDATE: begin
                if (cnt_q == CNT_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SHIFT: shift_en = sclk_rise & ~latch_rise;
            ST_UPDATE:         load_en  = (cnt_q == '0);
            default: ;
        endcase
    end

    dacin_shift #(.W(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sdi_s),
        .word_o   (shift_word),
        .msb_o    (shift_msb)
    );

    dacin_hold #(.W(WIDTH)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .load_en     (load_en),
        .word_i      (shift_word),
        .range_sel_i (range_sel_i),
        .code_o      (code_o),
        .upd_o       (upd_o),
        .clr_flag_o  (clr_flag_o),
        .span_o      (span_o)
    );

    assign sdo_o = shift_msb;

    // R4: the latched code equals the shift register at the load
    a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        load_en |=> (code_o == $past(shift_word) && upd_o));

    // R5: shift register frozen inside the update window
    a_r5_update_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE) |=> $stable(shift_word));

    // R3: after a shift the serial output carries the previous bit below the MSB
    a_r3_sdo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sdo_o == $past(shift_word[WIDTH-2])));

    // R6: no update pulse while clear is held
    a_r6_no_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !upd_o);

endmodule

// File: tb/test_dacin_serial_front.sv
`timescale 1ns/1ps
module test_dacin_serial_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, latch = 1'b0, clr = 1'b0;
    logic [1:0]  rsel = 2'b00;
    logic        sdo_n, sdo_f, upd_n, upd_f, cf_n, cf_f;
    logic [15:0] code_n, code_f;
    logic [3:0]  span_n, span_f;

    int vectors = 0;
    int fails   = 0;
    logic [15:0] q_near[$];
    logic [15:0] q_far[$];

    always #2 clk = ~clk;

    dacin_serial_front i_dacin_serial_front (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .latch_i(latch),
        .clr_i(clr), .range_sel_i(rsel), .sdo_o(sdo_n), .code_o(code_n),
        .upd_o(upd_n), .clr_flag_o(cf_n), .span_o(span_n));

    dacin_serial_front i_dacin_serial_front_far (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdo_n), .latch_i(latch),
        .clr_i(clr), .range_sel_i(rsel), .sdo_o(sdo_f), .code_o(code_f),
        .upd_o(upd_f), .clr_flag_o(cf_f), .span_o(span_f));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every update pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && upd_n) begin
            if (q_near.size() == 0) chk("R4/R6 near unexpected update", 32'(code_n), 32'hDEAD);
            else chk("R4 near code", 32'(code_n), 32'(q_near.pop_front()));
        end
        if (rst_n && upd_f) begin
            if (q_far.size() == 0) chk("R4/R6 far unexpected update", 32'(code_f), 32'hDEAD);
            else chk("R3 far code", 32'(code_f), 32'(q_far.pop_front()));
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        repeat (8) @(negedge clk);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_latch();
        @(negedge clk); sclk = 1'b0; latch = 1'b1;
        repeat (8) @(negedge clk);
        latch = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // Driver: shift 32 bits (far word first), record expectations, then latch (R2, R3)
    task automatic chain_load(input logic [15:0] far_w, input logic [15:0] near_w);
        for (int i = 15; i >= 0; i--) send_bit(far_w[i]);
        for (int i = 15; i >= 0; i--) send_bit(near_w[i]);
        repeat (4) @(negedge clk);
        chk("R3 near sdo is MSB", 32'(sdo_n), 32'(near_w[15]));
        chk("R3 far sdo is MSB", 32'(sdo_f), 32'(far_w[15]));
        q_near.push_back(near_w);
        q_far.push_back(far_w);
        pulse_latch();
        chk("R2 near word held", 32'(code_n), 32'(near_w));
        chk("R2 far word held", 32'(code_f), 32'(far_w));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code", 32'(code_n), 0);
        chk("R1 far code", 32'(code_f), 0);
        chk("R1 upd", 32'(upd_n), 0);
        chk("R1 clr flag", 32'(cf_n), 0);
        chk("R1 sdo", 32'(sdo_n), 0);

        // R8 span decode
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); rsel = 2'(v);
            repeat (3) @(negedge clk);
            chk("R8 span", 32'(span_n), 32'(1 << v));
        end

        // R2, R3, R4 chained patterns
        chain_load(16'hA5A5, 16'h3C0F);
        chain_load(16'hFFFF, 16'h0000);
        chain_load(16'h8001, 16'h7FFE);

        // R5: serial clock edge inside the update window is ignored
        q_near.push_back(16'h7FFE);
        q_far.push_back(16'h8001);
        @(negedge clk); latch = 1'b1;
        repeat (2) @(negedge clk);
        sdi = 1'b1; sclk = 1'b1;
        repeat (6) @(negedge clk);
        sclk = 1'b0; latch = 1'b0; sdi = 1'b0;
        repeat (10) @(negedge clk);
        q_near.push_back(16'h7FFE);
        q_far.push_back(16'h8001);
        pulse_latch();
        chk("R5 near word unchanged", 32'(code_n), 32'h7FFE);
        chk("R5 far word unchanged", 32'(code_f), 32'h8001);

        // R6: clear forces bottom, blocks latch
        @(negedge clk); clr = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 code during clear", 32'(code_n), 0);
        chk("R6 far code during clear", 32'(code_f), 0);
        chk("R6 clr flag", 32'(cf_n), 1);
        pulse_latch();
        chk("R6 code after latch in clear", 32'(code_n), 0);
        @(negedge clk); clr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 clr flag released", 32'(cf_n), 0);
        chk("R6 code stays bottom", 32'(code_n), 0);

        // R7: shift register survives the clear
        q_near.push_back(16'h7FFE);
        q_far.push_back(16'h8001);
        pulse_latch();
        chk("R7 near restored", 32'(code_n), 32'h7FFE);
        chk("R7 far restored", 32'(code_f), 32'h8001);

        chk("R4 near queue drained", 32'(q_near.size()), 0);
        chk("R4 far queue drained", 32'(q_far.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule